// File: doc/BRIEF.md
# Dual-Law PCM Sample Compander

This block converts voice samples between a 14-bit two's-complement linear form and the 8-bit companded characters used on a telephony line. It has two independent paths. The encoder path turns a linear sample into a code. The decoder path turns a received code back into a linear sample. Each path has its own valid strobe and produces its result one clock after the strobe.

A single law-select input chooses mu-law or A-law for both paths at run time. The select is captured in a register, and a sample always uses the law held in that register at the edge that accepts it, so a conversion never mixes the two laws. After reset the block is in mu-law mode, as though the select were weakly held low.

In A-law mode, bits 0, 2, 4 and 6 are inverted on the line side. In both laws the code's bit 7 is the sign and is the first bit sent on the serial line.

Top module: `pcm_compander`

## Requirements
- R1: While rst_n is low, enc_valid_o and dec_valid_o are 0, enc_code_o is 8'h00 and dec_lin_o is 0. The registered law resets to mu-law, so a sample accepted on the first edge after reset is encoded in mu-law even when law_sel is already 1.
- R2: law_sel is registered on every clock edge (0 = mu-law, 1 = A-law). A sample accepted on an edge uses the law_sel value captured on the previous edge. A sample presented in the same cycle as a change of law_sel is therefore converted with the old law.
- R3: mu-law encoding works as follows. The magnitude is the input for a non-negative input and its bitwise inverse for a negative input. The magnitude is limited to 8158, then 33 is added. The segment s is the position of the leading one in bits 12..5 of that sum, minus 5. The mantissa is sum bits [s+4:s+1]. The code is the bitwise inverse of {sign, s[2:0], mantissa}, where sign is 1 for a negative input. Examples: 0 gives 8'hFF, -1 gives 8'h7F, 100 gives 8'hDF, -100 gives 8'h5F and 5000 gives 8'h8C.
- R4: A-law encoding works as follows. The input is first reduced to 13 bits (bits 13..1). The magnitude is that value, or its bitwise inverse if it is negative, taken over 12 bits. If the magnitude is below 32, the segment is 0 and the mantissa is magnitude bits [4:1]. Otherwise the segment is 1 plus the leading-one position in magnitude bits 11..5, and the mantissa is magnitude bits [seg+3:seg]. The code is {non-negative, seg, mantissa} XOR 8'h55. Examples: 0 gives 8'hD5, -1 gives 8'h55, 20 gives 8'hD0 and 100 gives 8'hCC.
- R5: Inputs beyond the largest encodable magnitude saturate to full scale. In mu-law, 8158 and 8191 give 8'h80 and -8192 gives 8'h00. In A-law, 8191 gives 8'hAA and -8192 gives 8'h2A.
- R6: mu-law decoding inverts the code to get u. u[7] set means negative, seg = u[6:4] and mant = u[3:0]. The magnitude is (((2*mant)+33) << seg) - 33. Examples: 8'hFF and 8'h7F give 0, 8'h80 gives 8031, 8'h00 gives -8031 and 8'hDF gives 99.
- R7: A-law decoding XORs the code with 8'h55 to get a. a[7] set means non-negative, seg = a[6:4] and mant = a[3:0]. The 13-bit value t is 2*mant+1 when seg is 0, and ((2*mant)+33) << (seg-1) otherwise. The output is 2t with the sign applied. Examples: 8'hD5 gives 2, 8'h55 gives -2, 8'hAA gives 8064, 8'h2A gives -8064 and 8'hCC gives 102.
- R8: Encoding an unsaturated sample and then decoding the code in the same law returns a value within half a quantization step of the input, plus a small truncation allowance.
- R9: enc_valid_o and dec_valid_o follow enc_valid_i and dec_valid_i with exactly one cycle of delay. The result is presented in that same cycle.
- R10: When a path's input strobe is low, that path's data output keeps its previous value, whatever the input data is.
- R11: The encoder and decoder paths can accept samples in the same cycle without affecting each other, and both use the same registered law.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| law_sel | input | 1 | Law select, 0 = mu-law, 1 = A-law |
| enc_valid_i | input | 1 | Linear sample strobe |
| enc_lin_i | input | 14 | Linear sample, two's complement |
| dec_valid_i | input | 1 | Code strobe |
| dec_code_i | input | 8 | Received companded code |
| enc_valid_o | output | 1 | Code result strobe |
| enc_code_o | output | 8 | Companded code result |
| dec_valid_o | output | 1 | Linear result strobe |
| dec_lin_o | output | 14 | Linear result, two's complement |

## Verification
Three events can fall on the same edge: an encoder acceptance, a decoder acceptance and a change of law_sel. The bench provokes this by raising both strobes in the very cycle that law_sel toggles. It then judges the two results against the law in force before the toggle. Holding the same inputs for one more cycle must give both results under the new law. Each path's output is also compared with the value it would have had if the other path were idle.

// File: rtl/pcm_compander_pkg.sv
package pcm_compander_pkg;
   typedef enum logic {
      LAW_MU = 1'b0,
      LAW_A  = 1'b1
   } law_e;

   localparam int CODE_W      = 8;
   localparam int SEG_W       = 3;
   localparam int MANT_W      = 4;
   localparam int MU_BIAS     = 33;
   localparam int MU_CLIP     = 8158;
   localparam logic [CODE_W-1:0] A_EVEN_MASK = 8'h55;
endpackage

// File: rtl/pcm_cmp_lead1.sv
module pcm_cmp_lead1 #(
   parameter int W = 8,
   localparam int PW = (W > 1) ? $clog2(W) : 1
) (
   input  logic [W-1:0]  vec_i,
   output logic [PW-1:0] pos_o,
   output logic          hit_o
);
   // Scan from the bottom so that the highest set bit wins.
   always_comb begin
      pos_o = '0;
      hit_o = 1'b0;
      for (int i = 0; i < W; i++) begin
         if (vec_i[i]) begin
            pos_o = PW'(i);
            hit_o = 1'b1;
         end
      end
   end
endmodule

// File: rtl/pcm_cmp_mu_enc.sv
module pcm_cmp_mu_enc
   import pcm_compander_pkg::*;
#(
   parameter int LIN_W = 14,
   localparam int MAG_W = LIN_W - 1
) (
   input  logic [LIN_W-1:0]  lin_i,
   output logic [CODE_W-1:0] code_o
);
   logic              neg;
   logic [LIN_W-1:0]  mag_full;
   logic [MAG_W-1:0]  mag_clip;
   logic [MAG_W-1:0]  biased;
   logic [SEG_W-1:0]  seg_pos;
   logic              seg_hit;
   logic [SEG_W-1:0]  seg;
   logic [MANT_W-1:0] mant;
   logic              unused_lsb;

   assign neg      = lin_i[LIN_W-1];
   assign mag_full = neg ? ~lin_i : lin_i;
   assign mag_clip = (mag_full > LIN_W'(MU_CLIP)) ? MAG_W'(MU_CLIP) : mag_full[MAG_W-1:0];
   assign biased   = mag_clip + MAG_W'(MU_BIAS);

   pcm_cmp_lead1 #(.W(8)) u_seg (
      .vec_i (biased[MAG_W-1:MAG_W-8]),
      .pos_o (seg_pos),
      .hit_o (seg_hit)
   );

   assign seg        = seg_hit ? seg_pos : '0;
   assign mant       = biased[{1'b0, seg} + 4'd1 +: MANT_W];
   assign code_o     = ~{neg, seg, mant};
   assign unused_lsb = biased[0];
endmodule

// File: rtl/pcm_cmp_a_enc.sv
module pcm_cmp_a_enc
   import pcm_compander_pkg::*;
#(
   parameter int LIN_W = 14,
   localparam int RED_W = LIN_W - 1,
   localparam int MAG_W = RED_W - 1
) (
   input  logic [LIN_W-1:0]  lin_i,
   output logic [CODE_W-1:0] code_o
);
   logic [RED_W-1:0]  red;
   logic              neg;
   logic [MAG_W-1:0]  mag;
   logic [SEG_W-1:0]  lead_pos;
   logic              lead_hit;
   logic [SEG_W-1:0]  seg;
   logic [MANT_W-1:0] mant;
   logic              unused_bits;

   assign red = lin_i[LIN_W-1:1];
   assign neg = red[RED_W-1];
   assign mag = neg ? ~red[MAG_W-1:0] : red[MAG_W-1:0];

   pcm_cmp_lead1 #(.W(7)) u_seg (
      .vec_i (mag[MAG_W-1:MAG_W-7]),
      .pos_o (lead_pos),
      .hit_o (lead_hit)
   );

   always_comb begin
      if (lead_hit) begin
         seg  = lead_pos + 3'd1;
         mant = mag[{1'b0, seg} +: MANT_W];
      end else begin
         seg  = '0;
         mant = mag[4:1];
      end
   end

   assign code_o      = {~neg, seg, mant} ^ A_EVEN_MASK;
   assign unused_bits = lin_i[0] ^ mag[0];
endmodule

// File: rtl/pcm_cmp_decoder.sv
module pcm_cmp_decoder
   import pcm_compander_pkg::*;
#(
   parameter int LIN_W = 14
) (
   input  law_e              law_i,
   input  logic [CODE_W-1:0] code_i,
   output logic [LIN_W-1:0]  lin_o
);
   logic [CODE_W-1:0] u;
   logic [CODE_W-1:0] a;
   logic [6:0]        mu_base;
   logic [6:0]        a_base;
   logic [LIN_W-1:0]  mu_t;
   logic [LIN_W-1:0]  mu_mag;
   logic [LIN_W-1:0]  mu_lin;
   logic [LIN_W-2:0]  a_t;
   logic [LIN_W-1:0]  a_mag;
   logic [LIN_W-1:0]  a_lin;

   // mu-law: inverted character, segment midpoint minus the bias
   assign u       = ~code_i;
   assign mu_base = {2'b00, u[3:0], 1'b1} + 7'd32;
   assign mu_t    = LIN_W'(mu_base) << u[6:4];
   assign mu_mag  = mu_t - LIN_W'(MU_BIAS);
   assign mu_lin  = u[7] ? (LIN_W'(0) - mu_mag) : mu_mag;

   // A-law: undo even-bit inversion, linear first segment
   assign a      = code_i ^ A_EVEN_MASK;
   assign a_base = {2'b00, a[3:0], 1'b1} + 7'd32;

   always_comb begin
      if (a[6:4] == 3'd0) a_t = (LIN_W-1)'({a[3:0], 1'b1});
      else                a_t = (LIN_W-1)'(a_base) << (a[6:4] - 3'd1);
   end

   assign a_mag = {a_t, 1'b0};
   assign a_lin = a[7] ? a_mag : (LIN_W'(0) - a_mag);

   assign lin_o = (law_i == LAW_A) ? a_lin : mu_lin;
endmodule

// File: rtl/pcm_compander.sv
module pcm_compander
   import pcm_compander_pkg::*;
#(
   parameter int   LIN_W     = 14,
   parameter law_e RESET_LAW = LAW_MU
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              law_sel,
   input  logic              enc_valid_i,
   input  logic [LIN_W-1:0]  enc_lin_i,
   input  logic              dec_valid_i,
   input  logic [CODE_W-1:0] dec_code_i,
   output logic              enc_valid_o,
   output logic [CODE_W-1:0] enc_code_o,
   output logic              dec_valid_o,
   output logic [LIN_W-1:0]  dec_lin_o
);
   generate
      if (LIN_W != 14) begin : g_bad_width
         $error("pcm_compander: LIN_W must be 14");
      end
   endgenerate

   law_e              law_q;
   logic [CODE_W-1:0] mu_code;
   logic [CODE_W-1:0] a_code;
   logic [CODE_W-1:0] enc_code_d;
   logic [LIN_W-1:0]  dec_lin_d;

   pcm_cmp_mu_enc #(.LIN_W(LIN_W)) u_mu_enc (
      .lin_i  (enc_lin_i),
      .code_o (mu_code)
   );

   pcm_cmp_a_enc #(.LIN_W(LIN_W)) u_a_enc (
      .lin_i  (enc_lin_i),
      .code_o (a_code)
   );

   assign enc_code_d = (law_q == LAW_A) ? a_code : mu_code;

   pcm_cmp_decoder #(.LIN_W(LIN_W)) u_dec (
      .law_i  (law_q),
      .code_i (dec_code_i),
      .lin_o  (dec_lin_d)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         law_q       <= RESET_LAW;
         enc_valid_o <= 1'b0;
         enc_code_o  <= '0;
         dec_valid_o <= 1'b0;
         dec_lin_o   <= '0;
      end else begin
         law_q       <= law_e'(law_sel);
         enc_valid_o <= enc_valid_i;
         dec_valid_o <= dec_valid_i;
         if (enc_valid_i) enc_code_o <= enc_code_d;
         if (dec_valid_i) dec_lin_o  <= dec_lin_d;
      end
   end
endmodule

// File: rtl/pcm_compander_chk.sv
module pcm_compander_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        law_q,
   input logic        enc_valid_i,
   input logic [13:0] enc_lin_i,
   input logic        dec_valid_i,
   input logic [7:0]  dec_code_i,
   input logic        enc_valid_o,
   input logic [7:0]  enc_code_o,
   input logic        dec_valid_o,
   input logic [13:0] dec_lin_o
);
   a_r9_enc_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      enc_valid_i |=> enc_valid_o);
   a_r9_enc_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !enc_valid_i |=> !enc_valid_o);
   a_r9_dec_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid_i |=> dec_valid_o);
   a_r9_dec_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_valid_i |=> !dec_valid_o);
   a_r10_enc_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !enc_valid_i |=> $stable(enc_code_o));
   a_r10_dec_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_valid_i |=> $stable(dec_lin_o));
   a_r3_mu_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (enc_valid_i && !law_q && enc_lin_i == 14'd0) |=> enc_code_o == 8'hFF);
   a_r4_a_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (enc_valid_i && law_q && enc_lin_i == 14'd0) |=> enc_code_o == 8'hD5);
   a_r5_mu_sat: assert property (@(posedge clk) disable iff (!rst_n)
      (enc_valid_i && !law_q && !enc_lin_i[13] && enc_lin_i > 14'd8158)
      |=> enc_code_o == 8'h80);
   a_r6_mu_zero_dec: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid_i && !law_q && dec_code_i[6:0] == 7'h7F) |=> dec_lin_o == 14'd0);
   a_r7_a_sign: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid_i && law_q && dec_code_i[7]) |=> !dec_lin_o[13]);
endmodule

bind pcm_compander pcm_compander_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .law_q       (law_q),
   .enc_valid_i (enc_valid_i),
   .enc_lin_i   (enc_lin_i),
   .dec_valid_i (dec_valid_i),
   .dec_code_i  (dec_code_i),
   .enc_valid_o (enc_valid_o),
   .enc_code_o  (enc_code_o),
   .dec_valid_o (dec_valid_o),
   .dec_lin_o   (dec_lin_o)
);

// File: tb/pcm_compander_tb.sv
module pcm_compander_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        law_sel = 1'b0;
   logic        enc_valid_i = 1'b0;
   logic [13:0] enc_lin_i = '0;
   logic        dec_valid_i = 1'b0;
   logic [7:0]  dec_code_i = '0;
   logic        enc_valid_o;
   logic [7:0]  enc_code_o;
   logic        dec_valid_o;
   logic [13:0] dec_lin_o;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   pcm_compander u_dut (
      .clk(clk), .rst_n(rst_n), .law_sel(law_sel),
      .enc_valid_i(enc_valid_i), .enc_lin_i(enc_lin_i),
      .dec_valid_i(dec_valid_i), .dec_code_i(dec_code_i),
      .enc_valid_o(enc_valid_o), .enc_code_o(enc_code_o),
      .dec_valid_o(dec_valid_o), .dec_lin_o(dec_lin_o)
   );

   // {dir (0 enc, 1 dec), law, input, expected}
   localparam int NV = 24;
   localparam logic [29:0] VEC [NV] = '{
      {1'b0, 1'b0, 14'h0000, 14'h00FF}, {1'b0, 1'b0, 14'h3FFF, 14'h007F},
      {1'b0, 1'b0, 14'h1FFF, 14'h0080}, {1'b0, 1'b0, 14'h2000, 14'h0000},
      {1'b0, 1'b0, 14'h1FDE, 14'h0080}, {1'b0, 1'b0, 14'h1388, 14'h008C},
      {1'b0, 1'b0, 14'h0064, 14'h00DF}, {1'b0, 1'b0, 14'h3F9C, 14'h005F},
      {1'b0, 1'b1, 14'h0000, 14'h00D5}, {1'b0, 1'b1, 14'h3FFF, 14'h0055},
      {1'b0, 1'b1, 14'h1FFF, 14'h00AA}, {1'b0, 1'b1, 14'h2000, 14'h002A},
      {1'b0, 1'b1, 14'h0064, 14'h00CC}, {1'b0, 1'b1, 14'h0014, 14'h00D0},
      {1'b1, 1'b0, 14'h00FF, 14'h0000}, {1'b1, 1'b0, 14'h007F, 14'h0000},
      {1'b1, 1'b0, 14'h0080, 14'h1F5F}, {1'b1, 1'b0, 14'h0000, 14'h20A1},
      {1'b1, 1'b0, 14'h00DF, 14'h0063}, {1'b1, 1'b1, 14'h00D5, 14'h0002},
      {1'b1, 1'b1, 14'h0055, 14'h3FFE}, {1'b1, 1'b1, 14'h00AA, 14'h1F80},
      {1'b1, 1'b1, 14'h002A, 14'h2080}, {1'b1, 1'b1, 14'h00CC, 14'h0066}
   };

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   // law set one edge ahead, sample accepted on the next edge, checked at negedge
   task automatic run_enc(input bit law, input logic [13:0] lin, output logic [7:0] code);
      law_sel = law;
      @(negedge clk);
      enc_valid_i = 1'b1;
      enc_lin_i   = lin;
      @(negedge clk);
      enc_valid_i = 1'b0;
      code = enc_code_o;
   endtask

   task automatic run_dec(input bit law, input logic [7:0] code, output logic [13:0] lin);
      law_sel = law;
      @(negedge clk);
      dec_valid_i = 1'b1;
      dec_code_i  = code;
      @(negedge clk);
      dec_valid_i = 1'b0;
      lin = dec_lin_o;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      summary();
   end

   initial begin
      logic [7:0]  c;
      logic [13:0] y;
      // R1: reset state with law_sel held high
      law_sel = 1'b1;
      repeat (3) @(negedge clk);
      chk(enc_valid_o == 1'b0 && dec_valid_o == 1'b0, "R1 valids", {enc_valid_o, dec_valid_o}, 0);
      chk(enc_code_o == 8'h00 && dec_lin_o == 14'h0, "R1 data", int'(enc_code_o) + int'(dec_lin_o), 0);
      rst_n       = 1'b1;
      enc_valid_i = 1'b1;
      enc_lin_i   = 14'h0;
      @(negedge clk);
      enc_valid_i = 1'b0;
      chk(enc_code_o == 8'hFF, "R1 reset law mu", enc_code_o, 8'hFF);

      // table walk
      for (int i = 0; i < NV; i++) begin
         if (VEC[i][29] == 1'b0) begin
            run_enc(VEC[i][28], VEC[i][27:14], c);
            chk(c == VEC[i][7:0], VEC[i][28] ? "R4 R5 A-law encode" : "R3 R5 mu-law encode",
                c, int'(VEC[i][7:0]));
         end else begin
            run_dec(VEC[i][28], VEC[i][21:14], y);
            chk(y == VEC[i][13:0], VEC[i][28] ? "R7 A-law decode" : "R6 mu-law decode",
                $signed(y), $signed(VEC[i][13:0]));
         end
      end

      // R2: change law in the same cycle as a sample
      law_sel = 1'b0;
      @(negedge clk);
      @(negedge clk);
      law_sel     = 1'b1;
      enc_valid_i = 1'b1;
      enc_lin_i   = 14'h0;
      @(negedge clk);
      chk(enc_code_o == 8'hFF, "R2 old law applies", enc_code_o, 8'hFF);
      @(negedge clk);
      enc_valid_i = 1'b0;
      chk(enc_code_o == 8'hD5, "R2 new law applies", enc_code_o, 8'hD5);

      // R9: strobe delay, R10: hold with strobe low
      chk(enc_valid_o == 1'b1, "R9 valid after strobe", enc_valid_o, 1);
      enc_lin_i = 14'h1FFF;
      @(negedge clk);
      chk(enc_valid_o == 1'b0, "R9 valid drops", enc_valid_o, 0);
      chk(enc_code_o == 8'hD5, "R10 encoder hold", enc_code_o, 8'hD5);
      dec_code_i = 8'h00;
      @(negedge clk);
      chk(dec_lin_o == 14'h0066 && dec_valid_o == 1'b0, "R10 decoder hold",
          $signed(dec_lin_o), 102);

      // R11: both paths and a law toggle in one cycle (A -> mu)
      enc_valid_i = 1'b1;
      enc_lin_i   = 14'h0;
      dec_valid_i = 1'b1;
      dec_code_i  = 8'hAA;
      law_sel     = 1'b0;
      @(negedge clk);
      chk(enc_code_o == 8'hD5, "R11 encoder under old A-law", enc_code_o, 8'hD5);
      chk(dec_lin_o == 14'h1F80, "R11 decoder under old A-law", $signed(dec_lin_o), 8064);
      @(negedge clk);
      enc_valid_i = 1'b0;
      dec_valid_i = 1'b0;
      chk(enc_code_o == 8'hFF, "R11 encoder under mu-law", enc_code_o, 8'hFF);
      chk(dec_lin_o == 14'd1343, "R11 decoder under mu-law", $signed(dec_lin_o), 1343);
      chk(enc_valid_o && dec_valid_o, "R9 R11 both strobes", {enc_valid_o, dec_valid_o}, 3);

      // R8: round trip sweep for both laws
      for (int law = 0; law < 2; law++) begin
         for (int x = -7900; x <= 7900; x += 37) begin
            int yv, err, seg, bound;
            run_enc(law[0], 14'(x), c);
            run_dec(law[0], c, y);
            yv  = $signed(y);
            err = (yv > x) ? yv - x : x - yv;
            if (law == 0) begin
               seg   = int'(((~c) >> 4) & 8'h07);
               bound = (1 << seg) + 2;
            end else begin
               seg   = int'(((c ^ 8'h55) >> 4) & 8'h07);
               bound = ((seg == 0) ? 2 : (2 << (seg - 1))) + 4;
            end
            chk(err <= bound, law ? "R8 A-law round trip" : "R8 mu-law round trip", yv, x);
         end
      end

      summary();
   end
endmodule